// File: doc/BRIEF.md
# Floppy Controller Phase Sequencer

This block is the host-facing phase engine of a PC-style floppy disk controller. A CPU reaches it through a byte-wide port with eight offsets. It writes an opcode and its parameter bytes into the data FIFO offset. Then it either streams sector data out of the same offset in programmed-I/O mode, or it waits. Last, it reads the result bytes back. The main status offset tells the host at every moment whether the block wants a byte, whether the next transfer goes towards the host, and whether a command is in progress. An interrupt line marks the time during which results wait to be collected.

The drive is replaced by a simple sector-data source. Each byte is the low eight bits of its offset inside the sector, XORed with the sector number. The block supports these commands:
- sector read (opcode 0xE6);
- verify (0x16);
- read-ID (0x0A), which reports the cylinder last addressed by a read or verify.

Any other opcode is rejected with a one-byte result.

Top module: `fdc_phase_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first command, the main status (offset 4) reads 0x80, `irq` is 0, offset 2 reads 0x00, and a data FIFO (offset 5) read returns 0x00. Reset is asynchronous and active low, and its release takes effect after two clock edges.
- R2: After an accepted opcode byte and until its last parameter byte, the main status reads 0x90 (request bit 0x80 plus busy bit 0x10), and `irq` stays 0.
- R3: Read and verify take 8 parameter bytes after the opcode, in this order: select (bit 2 head, bits 1:0 drive), cylinder, head, first sector, size code, end sector, gap, data length. For a read with bit 3 of offset 2 cleared and a valid first sector, the main status reads 0xF0 from the cycle after the ninth byte until the last data byte is read.
- R4: Data-phase bytes number (E − F + 1) × (128 << min(size code, 7)). Here F is the first sector and E is the lesser of the end sector and SPT (18 by default). Byte k of sector s reads (k mod 256) XOR s, and each FIFO read advances to the next byte.
- R5: When the result phase starts, the main status reads 0xD0 and `irq` becomes 1. Read and verify then return 7 bytes from offset 5.
- R6: Result bytes of a read or verify are returned in this order:
  - ST0, which is 0x04 OR drive when the end sector does not exceed SPT and the first sector is valid;
  - ST1 = 0x00 and ST2 = 0x00;
  - the cylinder parameter;
  - the head parameter;
  - E;
  - the size code parameter.
- R7: A read or verify is out of range when the end sector exceeds SPT, or when the first sector is 0 or greater than E. It then reports ST0 = 0x44 OR drive and ST1 = 0x80. If the first sector is valid, sectors F..SPT are still streamed. An invalid first sector streams no data and goes straight to the result phase.
- R8: A verify, or a read while bit 3 of offset 2 is set, enters the result phase (0xD0) in the cycle after the ninth byte, with no data phase.
- R9: `irq` stays 1 until the final result byte is read. In the cycle after that read, the main status reads 0x80 and `irq` is 0.
- R10: Read-ID takes one select byte. The main status then reads 0x10 for exactly ID_WAIT cycles (20 by default). After that, 7 result bytes follow in this order:
  - select[2:0];
  - 0x00 and 0x00;
  - the cylinder of the last read or verify (0 after reset);
  - select bit 2;
  - 0x01;
  - 0x02.
- R11: Any opcode other than 0xE6, 0x16 and 0x0A goes straight to the result phase, with `irq` at 1 and a single result byte of 0x80.
- R12: The following accesses change no phase, byte position or result:
  - a FIFO write while the main status direction bit 0x40 is set;
  - a FIFO write during read-ID execution;
  - a FIFO read while the direction bit is clear, which returns 0x00;
  - any access to offsets 0, 1, 3, 4 (write), 6 and 7.

  Offsets 0, 1, 3, 6 and 7 read 0x00, and offset 2 reads back the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; a FIFO read consumes the byte shown on bus_rdata |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | High while results wait to be read |

## Verification
The bench goes after the sector-boundary corner cases:
- a single sector;
- a full 18-sector track;
- an end sector one past the track;
- a first sector beyond the end sector;
- size codes 0 to 2.

A design that wraps its byte counter wrongly streams the wrong byte count, and the status flips from 0xF0 early or late. A wrong overrun test reports 0x04 where 0x44 is due. It also tests the interrupt edges, because a design that drops the interrupt one byte early or late leaves the host in the wrong phase. Stray FIFO accesses during the result phase and during read-ID execution, together with a burst of random accesses to all eight offsets, catch a phase machine that accepts bytes it should ignore. Such a machine would skip or repeat result bytes.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PARAM,
    PH_EXEC,
    PH_DATA,
    PH_RESULT
  } phase_e;

  typedef enum logic [1:0] {
    RK_XFER,
    RK_ID,
    RK_BAD
  } res_kind_e;

  localparam logic [7:0] OP_READ    = 8'hE6;
  localparam logic [7:0] OP_VERIFY  = 8'h16;
  localparam logic [7:0] OP_READ_ID = 8'h0A;

  localparam logic [7:0] MS_RQM  = 8'h80;
  localparam logic [7:0] MS_DIO  = 8'h40;
  localparam logic [7:0] MS_PIO  = 8'h20;
  localparam logic [7:0] MS_BUSY = 8'h10;

  localparam logic [2:0] OFS_DOR  = 3'd2;
  localparam logic [2:0] OFS_MSR  = 3'd4;
  localparam logic [2:0] OFS_FIFO = 3'd5;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_pkg::*;
(
  input  logic [7:0] opcode,
  output logic [3:0] n_params,
  output res_kind_e  kind,
  output logic       is_read
);

  always_comb begin
    n_params = 4'd0;
    kind     = RK_BAD;
    is_read  = 1'b0;
    case (opcode)
      OP_READ: begin
        n_params = 4'd8;
        kind     = RK_XFER;
        is_read  = 1'b1;
      end
      OP_VERIFY: begin
        n_params = 4'd8;
        kind     = RK_XFER;
      end
      OP_READ_ID: begin
        n_params = 4'd1;
        kind     = RK_ID;
      end
      default: begin
        n_params = 4'd0;
        kind     = RK_BAD;
      end
    endcase
  end

endmodule

// File: rtl/fdc_sector_src.sv
module fdc_sector_src #(
  parameter int SPT           = 18,
  parameter int MAX_SIZE_CODE = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       adv,
  input  logic [7:0] first_sec,
  input  logic [7:0] eot,
  input  logic [7:0] size,
  output logic [7:0] data,
  output logic       last,
  output logic       has_data,
  output logic       overrun,
  output logic [7:0] end_sec
);

  localparam int OFF_W = 7 + MAX_SIZE_CODE;
  localparam int SZ_W  = $clog2(MAX_SIZE_CODE + 1);
  localparam logic [7:0] SPT8 = 8'(SPT);

  logic [OFF_W-1:0] off_q, off_n, off_last;
  logic [7:0]       sec_q, sec_n;
  logic [SZ_W-1:0]  sz_q, sz_n, sz_clamp;
  logic             bad_start;

  // Geometry checks on the stored command parameters
  always_comb begin
    end_sec   = (eot > SPT8) ? SPT8 : eot;
    bad_start = (first_sec == 8'd0) || (first_sec > end_sec);
    overrun   = (eot > SPT8) || bad_start;
    has_data  = !bad_start;
    sz_clamp  = (size > 8'(MAX_SIZE_CODE)) ? SZ_W'(MAX_SIZE_CODE) : size[SZ_W-1:0];
  end

  assign off_last = {OFF_W{1'b1}} >> (MAX_SIZE_CODE - int'(sz_q));
  assign data     = off_q[7:0] ^ sec_q;
  assign last     = (off_q == off_last) && (sec_q == end_sec);

  always_comb begin
    off_n = off_q;
    sec_n = sec_q;
    sz_n  = sz_q;
    if (start) begin
      off_n = '0;
      sec_n = first_sec;
      sz_n  = sz_clamp;
    end else if (adv) begin
      if (off_q == off_last) begin
        off_n = '0;
        sec_n = sec_q + 8'd1;
      end else begin
        off_n = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      sec_q <= '0;
      sz_q  <= '0;
    end else if (start || adv) begin
      off_q <= off_n;
      sec_q <= sec_n;
      sz_q  <= sz_n;
    end
  end

  AST_SRC_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= off_last);  // R4

  AST_SRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !start && (off_q == off_last) |=> (off_q == '0) && (sec_q == $past(sec_q) + 8'd1));  // R4

endmodule

// File: rtl/fdc_result_gen.sv
module fdc_result_gen
  import fdc_pkg::*;
(
  input  res_kind_e  kind,
  input  logic [2:0] idx,
  input  logic [2:0] sel,
  input  logic [7:0] cyl,
  input  logic [7:0] headp,
  input  logic [7:0] end_sec,
  input  logic [7:0] size,
  input  logic [7:0] cur_cyl,
  input  logic       overrun,
  output logic [7:0] res_byte,
  output logic [2:0] last_idx
);

  logic [7:0] st0_xfer;

  assign st0_xfer = (overrun ? 8'h44 : 8'h04) | {6'd0, sel[1:0]};

  always_comb begin
    res_byte = 8'h00;
    last_idx = 3'd6;
    case (kind)
      RK_XFER: begin
        case (idx)
          3'd0:    res_byte = st0_xfer;
          3'd1:    res_byte = overrun ? 8'h80 : 8'h00;
          3'd2:    res_byte = 8'h00;
          3'd3:    res_byte = cyl;
          3'd4:    res_byte = headp;
          3'd5:    res_byte = end_sec;
          3'd6:    res_byte = size;
          default: res_byte = 8'h00;
        endcase
      end
      RK_ID: begin
        case (idx)
          3'd0:    res_byte = {5'd0, sel};
          3'd3:    res_byte = cur_cyl;
          3'd4:    res_byte = {7'd0, sel[2]};
          3'd5:    res_byte = 8'h01;
          3'd6:    res_byte = 8'h02;
          default: res_byte = 8'h00;
        endcase
      end
      default: begin
        res_byte = 8'h80;
        last_idx = 3'd0;
      end
    endcase
  end

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_pkg::*;
#(
  parameter int SPT           = 18,
  parameter int ID_WAIT       = 20,
  parameter int MAX_SIZE_CODE = 7,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);

  localparam int TMR_W = $clog2(ID_WAIT + 1);

  // Reset release synchronizer
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[g] <= 1'b0;
        else        rst_pipe[g] <= (g == 0) ? 1'b1 : rst_pipe[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // State
  phase_e           phase_q, phase_n;
  logic [7:0]       opcode_q, opcode_n;
  logic [3:0]       pidx_q, pidx_n;
  logic [2:0]       sel_q, sel_n;
  logic [7:0]       cyl_q, cyl_n;
  logic [7:0]       headp_q, headp_n;
  logic [7:0]       sec_q, sec_n;
  logic [7:0]       size_q, size_n;
  logic [7:0]       eot_q, eot_n;
  logic [7:0]       dor_q, dor_n;
  logic [7:0]       ccyl_q, ccyl_n;
  logic [2:0]       ridx_q, ridx_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             irq_q, irq_n;

  logic             fifo_wr, fifo_rd;
  logic [7:0]       dec_in;
  logic [3:0]       n_params;
  res_kind_e        kind;
  logic             is_read;
  logic             src_start, src_adv;
  logic [7:0]       src_data, src_end;
  logic             src_last, src_has, src_over;
  logic [7:0]       res_byte;
  logic [2:0]       res_last;
  logic [7:0]       msr;

  assign fifo_wr = bus_wr && (bus_addr == OFS_FIFO);
  assign fifo_rd = bus_rd && (bus_addr == OFS_FIFO);
  assign dec_in  = (phase_q == PH_IDLE) ? bus_wdata : opcode_q;

  fdc_cmd_decode i_dec (
    .opcode   (dec_in),
    .n_params (n_params),
    .kind     (kind),
    .is_read  (is_read)
  );

  fdc_sector_src #(
    .SPT           (SPT),
    .MAX_SIZE_CODE (MAX_SIZE_CODE)
  ) i_src (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (src_start),
    .adv       (src_adv),
    .first_sec (sec_q),
    .eot       (eot_q),
    .size      (size_q),
    .data      (src_data),
    .last      (src_last),
    .has_data  (src_has),
    .overrun   (src_over),
    .end_sec   (src_end)
  );

  fdc_result_gen i_res (
    .kind     (kind),
    .idx      (ridx_q),
    .sel      (sel_q),
    .cyl      (cyl_q),
    .headp    (headp_q),
    .end_sec  (src_end),
    .size     (size_q),
    .cur_cyl  (ccyl_q),
    .overrun  (src_over),
    .res_byte (res_byte),
    .last_idx (res_last)
  );

  // Status as seen by the host
  always_comb begin
    case (phase_q)
      PH_IDLE:   msr = MS_RQM;
      PH_PARAM:  msr = MS_RQM | MS_BUSY;
      PH_EXEC:   msr = MS_BUSY;
      PH_DATA:   msr = MS_RQM | MS_DIO | MS_PIO | MS_BUSY;
      PH_RESULT: msr = MS_RQM | MS_DIO | MS_BUSY;
      default:   msr = MS_RQM;
    endcase
  end

  always_comb begin
    case (bus_addr)
      OFS_DOR: bus_rdata = dor_q;
      OFS_MSR: bus_rdata = msr;
      OFS_FIFO: begin
        if (phase_q == PH_DATA)        bus_rdata = src_data;
        else if (phase_q == PH_RESULT) bus_rdata = res_byte;
        else                           bus_rdata = 8'h00;
      end
      default: bus_rdata = 8'h00;
    endcase
  end

  // Next-state logic
  always_comb begin
    phase_n   = phase_q;
    opcode_n  = opcode_q;
    pidx_n    = pidx_q;
    sel_n     = sel_q;
    cyl_n     = cyl_q;
    headp_n   = headp_q;
    sec_n     = sec_q;
    size_n    = size_q;
    eot_n     = eot_q;
    ccyl_n    = ccyl_q;
    ridx_n    = ridx_q;
    tmr_n     = tmr_q;
    irq_n     = irq_q;
    src_start = 1'b0;
    src_adv   = 1'b0;
    dor_n     = (bus_wr && (bus_addr == OFS_DOR)) ? bus_wdata : dor_q;

    case (phase_q)
      PH_IDLE: begin
        if (fifo_wr) begin
          opcode_n = bus_wdata;
          pidx_n   = 4'd0;
          if (n_params == 4'd0) begin
            phase_n = PH_RESULT;
            ridx_n  = 3'd0;
            irq_n   = 1'b1;
          end else begin
            phase_n = PH_PARAM;
          end
        end
      end
      PH_PARAM: begin
        if (fifo_wr) begin
          case (pidx_q)
            4'd0:    sel_n   = bus_wdata[2:0];
            4'd1:    cyl_n   = bus_wdata;
            4'd2:    headp_n = bus_wdata;
            4'd3:    sec_n   = bus_wdata;
            4'd4:    size_n  = bus_wdata;
            4'd5:    eot_n   = bus_wdata;
            default: ;
          endcase
          pidx_n = pidx_q + 4'd1;
          if (pidx_q == n_params - 4'd1) begin
            ridx_n = 3'd0;
            if (kind == RK_ID) begin
              phase_n = PH_EXEC;
              tmr_n   = TMR_W'(ID_WAIT - 1);
            end else begin
              ccyl_n = cyl_q;
              if (is_read && !dor_q[3] && src_has) begin
                phase_n   = PH_DATA;
                src_start = 1'b1;
              end else begin
                phase_n = PH_RESULT;
                irq_n   = 1'b1;
              end
            end
          end
        end
      end
      PH_EXEC: begin
        if (tmr_q == '0) begin
          phase_n = PH_RESULT;
          irq_n   = 1'b1;
        end else begin
          tmr_n = tmr_q - 1'b1;
        end
      end
      PH_DATA: begin
        if (fifo_rd) begin
          src_adv = 1'b1;
          if (src_last) begin
            phase_n = PH_RESULT;
            irq_n   = 1'b1;
          end
        end
      end
      PH_RESULT: begin
        if (fifo_rd) begin
          if (ridx_q == res_last) begin
            phase_n = PH_IDLE;
            irq_n   = 1'b0;
          end else begin
            ridx_n = ridx_q + 3'd1;
          end
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q  <= PH_IDLE;
      opcode_q <= 8'h00;
      pidx_q   <= 4'd0;
      sel_q    <= 3'd0;
      cyl_q    <= 8'h00;
      headp_q  <= 8'h00;
      sec_q    <= 8'h00;
      size_q   <= 8'h00;
      eot_q    <= 8'h00;
      dor_q    <= 8'h00;
      ccyl_q   <= 8'h00;
      ridx_q   <= 3'd0;
      tmr_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      opcode_q <= opcode_n;
      pidx_q   <= pidx_n;
      sel_q    <= sel_n;
      cyl_q    <= cyl_n;
      headp_q  <= headp_n;
      sec_q    <= sec_n;
      size_q   <= size_n;
      eot_q    <= eot_n;
      dor_q    <= dor_n;
      ccyl_q   <= ccyl_n;
      ridx_q   <= ridx_n;
      tmr_q    <= tmr_n;
      irq_q    <= irq_n;
    end
  end

  assign irq = irq_q;

  AST_IRQ_LOW_IN_PARAMS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_PARAM) |-> !irq_q);  // R2

  AST_IRQ_ONLY_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_q |-> (phase_q == PH_RESULT));  // R5

  AST_RESULT_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_RESULT) |-> (ridx_q <= res_last));  // R5

  AST_IRQ_DROP_LAST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_RESULT) && fifo_rd && (ridx_q == res_last) |=> !irq_q && (phase_q == PH_IDLE));  // R9

  AST_EXEC_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_EXEC) |-> (tmr_q < TMR_W'(ID_WAIT)));  // R10

  AST_RESULT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_RESULT) && fifo_wr && !bus_rd |=> (phase_q == PH_RESULT) && $stable(ridx_q));  // R12

  AST_EXEC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_EXEC) && fifo_wr |=> $stable(sel_q) && $stable(pidx_q));  // R12

endmodule

// File: tb/test_fdc_phase_seq.sv
module test_fdc_phase_seq;

  localparam int SPT     = 18;
  localparam int ID_WAIT = 20;

  localparam int MIDLE = 0, MPARAM = 1, MEXEC = 2, MDATA = 3, MRES = 4;

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_checks;
  int n_fail;
  int cyc;
  bit model_on;
  bit done;

  fdc_phase_seq #(
    .SPT           (SPT),
    .ID_WAIT       (ID_WAIT),
    .MAX_SIZE_CODE (7),
    .SYNC_STAGES   (2)
  ) i_fdc_phase_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int         mph;
  int         mneed, mk, mtimer;
  logic [7:0] mp [8];
  logic [7:0] mdor, mcyl;
  logic [7:0] mdq [$];
  logic [7:0] mrq [$];

  task automatic m_finish_xfer(input logic [7:0] op);
    int first, eot, endsec, szc, nb;
    bit bad, over;
    first  = int'(mp[3]);
    eot    = int'(mp[5]);
    endsec = (eot > SPT) ? SPT : eot;
    bad    = (first == 0) || (first > endsec);
    over   = (eot > SPT) || bad;
    szc    = (mp[4] > 8'd7) ? 7 : int'(mp[4]);
    nb     = 128 << szc;
    mcyl   = mp[1];
    mrq.delete();
    mrq.push_back((over ? 8'h44 : 8'h04) | (mp[0] & 8'h03));
    mrq.push_back(over ? 8'h80 : 8'h00);
    mrq.push_back(8'h00);
    mrq.push_back(mp[1]);
    mrq.push_back(mp[2]);
    mrq.push_back(8'(endsec));
    mrq.push_back(mp[4]);
    if (op == 8'hE6 && !mdor[3] && !bad) begin
      mdq.delete();
      for (int s = first; s <= endsec; s++)
        for (int o = 0; o < nb; o++)
          mdq.push_back(8'(o & 255) ^ 8'(s));
      mph = MDATA;
    end else begin
      mph = MRES;
    end
  endtask

  logic [7:0] mop;

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = MIDLE; mdor = 8'h00; mcyl = 8'h00; mk = 0; mneed = 0; mtimer = 0;
      mdq.delete(); mrq.delete();
    end else begin
      case (mph)
        MIDLE: if (bus_wr && bus_addr == 3'd5) begin
          mop = bus_wdata;
          mk  = 0;
          if (mop == 8'hE6 || mop == 8'h16) begin mneed = 8; mph = MPARAM; end
          else if (mop == 8'h0A) begin mneed = 1; mph = MPARAM; end
          else begin mrq.delete(); mrq.push_back(8'h80); mph = MRES; end
        end
        MPARAM: if (bus_wr && bus_addr == 3'd5) begin
          mp[mk] = bus_wdata;
          mk++;
          if (mk == mneed) begin
            if (mop == 8'h0A) begin
              mrq.delete();
              mrq.push_back(mp[0] & 8'h07);
              mrq.push_back(8'h00);
              mrq.push_back(8'h00);
              mrq.push_back(mcyl);
              mrq.push_back((mp[0] >> 2) & 8'h01);
              mrq.push_back(8'h01);
              mrq.push_back(8'h02);
              mtimer = ID_WAIT - 1;
              mph = MEXEC;
            end else begin
              m_finish_xfer(mop);
            end
          end
        end
        MEXEC: begin
          if (mtimer == 0) mph = MRES;
          else mtimer--;
        end
        MDATA: if (bus_rd && bus_addr == 3'd5) begin
          void'(mdq.pop_front());
          if (mdq.size() == 0) mph = MRES;
        end
        MRES: if (bus_rd && bus_addr == 3'd5) begin
          void'(mrq.pop_front());
          if (mrq.size() == 0) mph = MIDLE;
        end
        default: mph = MIDLE;
      endcase
      if (bus_wr && bus_addr == 3'd2) mdor = bus_wdata;
    end
  end

  function automatic logic [7:0] m_msr();
    case (mph)
      MIDLE:   return 8'h80;
      MPARAM:  return 8'h90;
      MEXEC:   return 8'h10;
      MDATA:   return 8'hF0;
      default: return 8'hD0;
    endcase
  endfunction

  function automatic string m_tag();
    case (mph)
      MIDLE:   return "R1";
      MPARAM:  return "R2";
      MEXEC:   return "R10";
      MDATA:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk({m_tag(), " irq"}, {7'd0, irq}, {7'd0, mph == MRES});
      case (bus_addr)
        3'd2: chk("R12 offset2", bus_rdata, mdor);
        3'd4: chk({m_tag(), " status"}, bus_rdata, m_msr());
        3'd5: begin
          if (mph == MDATA)     chk("R4 data", bus_rdata, mdq[0]);
          else if (mph == MRES) chk("R6 result", bus_rdata, mrq[0]);
          else                  chk("R12 fifo idle", bus_rdata, 8'h00);
        end
        default: chk("R12 unused offset", bus_rdata, 8'h00);
      endcase
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #2;
    bus_rd = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic send_xfer(input logic [7:0] op, input logic [7:0] sel, input logic [7:0] cyl,
                           input logic [7:0] head, input logic [7:0] sec, input logic [7:0] sz,
                           input logic [7:0] eot);
    wr(3'd5, op);
    wr(3'd5, sel);
    chk_int("R2 irq low in params", int'(irq), 0);
    wr(3'd5, cyl);
    wr(3'd5, head);
    wr(3'd5, sec);
    wr(3'd5, sz);
    wr(3'd5, eot);
    wr(3'd5, 8'h1B);
    wr(3'd5, 8'hFF);
  endtask

  task automatic drain_data(output int n);
    logic [7:0] m, d;
    n = 0;
    for (int g = 0; g < 20000; g++) begin
      rd(3'd4, m);
      if (m != 8'hF0) break;
      rd(3'd5, d);
      n++;
    end
  endtask

  task automatic get_results(output logic [7:0] r [8], output int n);
    logic [7:0] m;
    n = 0;
    for (int g = 0; g < 8; g++) begin
      rd(3'd4, m);
      if (m != 8'hD0) break;
      rd(3'd5, r[n]);
      n++;
    end
  endtask

  task automatic chk_res(input string tag, input logic [7:0] r [8], input int n,
                         input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e3,
                         input logic [7:0] e4, input logic [7:0] e5, input logic [7:0] e6);
    chk_int({tag, " result count"}, n, 7);
    chk({tag, " ST0"}, r[0], e0);
    chk({tag, " ST1"}, r[1], e1);
    chk({tag, " ST2"}, r[2], 8'h00);
    chk({tag, " C"},   r[3], e3);
    chk({tag, " H"},   r[4], e4);
    chk({tag, " R"},   r[5], e5);
    chk({tag, " N"},   r[6], e6);
  endtask

  task automatic chk_back_idle(input string tag);
    logic [7:0] m;
    rd(3'd4, m);
    chk({tag, " idle status"}, m, 8'h80);
    chk_int({tag, " irq low"}, int'(irq), 0);
  endtask

  task automatic read_id(input logic [7:0] sel);
    logic [7:0] m;
    wr(3'd5, 8'h0A);
    rd(3'd4, m);
    chk("R2 status after opcode", m, 8'h90);
    wr(3'd5, sel);
    rd(3'd4, m);
    chk("R10 exec status", m, 8'h10);
    wr(3'd5, 8'h55);  // ignored during execution (R12)
    for (int g = 0; g < 100; g++) begin
      rd(3'd4, m);
      if (m == 8'hD0) break;
    end
    chk("R10 result reached", m, 8'hD0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] m, d;
    logic [7:0] r [8];
    int n;
    logic [15:0] lfsr;

    n_checks = 0; n_fail = 0; cyc = 0; model_on = 0; done = 0;
    bus_addr = 3'd4; bus_wr = 0; bus_rd = 0; bus_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    model_on = 1;
    @(negedge clk);
    chk("R1 status in reset", bus_rdata, 8'h80);
    chk_int("R1 irq in reset", int'(irq), 0);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(3'd4, m); chk("R1 status", m, 8'h80);
    chk_int("R1 irq", int'(irq), 0);
    rd(3'd2, m); chk("R1 offset2", m, 8'h00);

    // R12 stray accesses in idle
    rd(3'd5, m); chk("R12 fifo read in idle", m, 8'h00);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd4, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd0, m); chk("R12 offset0", m, 8'h00);
    rd(3'd1, m); chk("R12 offset1", m, 8'h00);
    rd(3'd7, m); chk("R12 offset7", m, 8'h00);
    rd(3'd4, m); chk("R12 status unchanged", m, 8'h80);

    // R10 read-ID after reset
    read_id(8'h00);
    get_results(r, n);
    chk_res("R10 id0", r, n, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02);
    chk_back_idle("R9 id0");

    // R3 single-sector read, PIO
    send_xfer(8'hE6, 8'h00, 8'h05, 8'h00, 8'h01, 8'h02, 8'h01);
    rd(3'd4, m); chk("R3 data status", m, 8'hF0);
    drain_data(n);
    chk_int("R4 byte count 1x512", n, 512 - 0);
    chk_int("R5 irq at result", int'(irq), 1);
    wr(3'd5, 8'hAA);  // R12 ignored write during results
    get_results(r, n);
    chk_res("R6 single", r, n, 8'h04, 8'h00, 8'h05, 8'h00, 8'h01, 8'h02);
    chk_back_idle("R9 single");

    // R6 full track
    send_xfer(8'hE6, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h12);
    drain_data(n);
    chk_int("R4 byte count 18x512", n, 18 * 512);
    get_results(r, n);
    chk_res("R6 track", r, n, 8'h04, 8'h00, 8'h00, 8'h00, 8'h12, 8'h02);
    chk_back_idle("R9 track");

    // R7 end sector past track
    send_xfer(8'hE6, 8'h01, 8'h03, 8'h00, 8'h01, 8'h01, 8'h13);
    drain_data(n);
    chk_int("R7 byte count 18x256", n, 18 * 256);
    get_results(r, n);
    chk_res("R7 overrun", r, n, 8'h45, 8'h80, 8'h03, 8'h00, 8'h12, 8'h01);
    chk_back_idle("R9 overrun");

    // R4 small sectors, head 1
    send_xfer(8'hE6, 8'h04, 8'h02, 8'h01, 8'h03, 8'h00, 8'h04);
    drain_data(n);
    chk_int("R4 byte count 2x128", n, 256);
    get_results(r, n);
    chk_res("R6 small", r, n, 8'h04, 8'h00, 8'h02, 8'h01, 8'h04, 8'h00);

    // R7 first sector beyond end: no data
    send_xfer(8'hE6, 8'h00, 8'h01, 8'h00, 8'h05, 8'h00, 8'h03);
    rd(3'd4, m); chk("R7 no data phase", m, 8'hD0);
    get_results(r, n);
    chk_res("R7 bad start", r, n, 8'h44, 8'h80, 8'h01, 8'h00, 8'h03, 8'h00);

    // R8 verify
    send_xfer(8'h16, 8'h00, 8'h08, 8'h00, 8'h01, 8'h02, 8'h05);
    rd(3'd4, m); chk("R8 verify status", m, 8'hD0);
    chk_int("R8 verify irq", int'(irq), 1);
    get_results(r, n);
    chk_res("R8 verify", r, n, 8'h04, 8'h00, 8'h08, 8'h00, 8'h05, 8'h02);

    // R8 read with DMA enable bit set
    wr(3'd2, 8'h08);
    rd(3'd2, m); chk("R12 offset2 readback", m, 8'h08);
    send_xfer(8'hE6, 8'h00, 8'h09, 8'h00, 8'h01, 8'h02, 8'h01);
    rd(3'd4, m); chk("R8 dma status", m, 8'hD0);
    get_results(r, n);
    chk_res("R8 dma", r, n, 8'h04, 8'h00, 8'h09, 8'h00, 8'h01, 8'h02);
    wr(3'd2, 8'h00);

    // R10 read-ID head 1 drive 2, cylinder from last command
    read_id(8'h06);
    get_results(r, n);
    chk_res("R10 id1", r, n, 8'h06, 8'h00, 8'h09, 8'h01, 8'h01, 8'h02);

    // R11 undefined opcode
    wr(3'd5, 8'h55);
    rd(3'd4, m); chk("R11 status", m, 8'hD0);
    chk_int("R11 irq", int'(irq), 1);
    get_results(r, n);
    chk_int("R11 result count", n, 1);
    chk("R11 result byte", r[0], 8'h80);
    chk_back_idle("R11");

    // R12 random accesses to all offsets
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3]) wr(lfsr[2:0], {4'd0, lfsr[11:8]});
      else         rd(lfsr[2:0], d);
    end
    for (int g = 0; g < 200; g++) begin
      rd(3'd4, m);
      if (m == 8'h80) break;
      if (m[6])            rd(3'd5, d);
      else if (m == 8'h90) wr(3'd5, 8'h00);
    end
    chk("R12 idle after random accesses", m, 8'h80);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule